// File: doc/BRIEF.md
# AUX Channel Transaction Retry Sequencer

This block sits between a host request port and a low-level AUX transceiver. The host submits a single request with these fields:

- a direction;
- a command code;
- a start address;
- a length of 1 to `MAX_LEN` bytes;
- for writes, the whole payload.

The sequencer checks that the command code belongs to the chosen direction. It then cuts the transfer into chunks of at most 16 bytes and starts one transceiver attempt per chunk. It watches each attempt against a 40 ms limit and sorts every reply into one of four classes: link error, defer, ACK, or anything else. When the request ends, it emits a one-cycle completion pulse carrying a status code and the number of bytes completed.

Link errors and defers each draw on a separate retry budget, and both budgets restart with every chunk. An ACK may cover fewer bytes than the chunk asked for. In that case the next chunk starts at the first byte not acknowledged, so the address and the payload offset always advance by exactly the acknowledged count.

The request port is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and the host must hold `req_valid` and every request field steady until a cycle in which both are high. The completion pulse and the transceiver handshake are plain strobes with no back-pressure.

Top module: `aux_retry_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `done_valid` and `xcv_start` are 0. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays 0 until the cycle after the one-cycle `done_valid` pulse.
- R2: Write requests accept only command codes 0, 4 and 8. Read requests accept only 1, 2, 5 and 9. The length must lie in 1..`MAX_LEN`. A request that fails any of these ends with status 1 and `done_bytes` 0, and never raises `xcv_start`.
- R3: Each attempt presents `xcv_addr` equal to the start address plus the bytes acknowledged so far. It presents `xcv_len_m1` equal to min(16, remaining) minus 1. For writes, byte i of `xcv_wdata` is payload byte (acknowledged count + i).
- R4: An attempt whose status has any of bits [3:0] set counts as a link error (timeout, receive error, sink status error, missing stop). It raises `xcv_stat_clr` for one cycle and is retried. The `ERR_TRIES`-th link error within one chunk ends the request with status 2.
- R5: With no error flag set, reply type 2 or 3 (status bits [5:4]) is a defer. A defer raises `xcv_stat_clr` and is retried from a separate budget. The `DEF_TRIES`-th defer within one chunk ends the request with status 3.
- R6: Reply type 0 is an ACK. Its byte count, in status bits [10:6] and clamped to the chunk size, is added to the address and offset. Only that many bytes of `xcv_rdata` are stored into `rd_data`, at the current offset.
- R7: Reply type 1, or an ACK whose byte count is 0, ends the request with status 4. `done_bytes` then counts the bytes of the earlier acknowledged chunks.
- R8: The first attempt of the first chunk starts in the cycle after the request is taken. A new chunk starts in the cycle after the previous ACK. A retry starts `SETTLE_CYC`+1 cycles after the cycle that ended the failed attempt.
- R9: An attempt with no `xcv_done` within `TMO_CYC` cycles after its start cycle counts as a link error.
- R10: A request whose acknowledged bytes reach its length ends with status 0 and `done_bytes` equal to the length.
- R11: Both retry budgets restart at every new chunk, so each chunk may use up to `ERR_TRIES`-1 link-error retries and `DEF_TRIES`-1 defer retries and still succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Start address |
| req_len | input | clog2(MAX_LEN+1) | Byte count |
| req_wdata | input | 8*MAX_LEN | Write payload, byte j at bits [8j+7:8j] |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 3 | 0 ok, 1 bad command, 2 error budget spent, 3 defer budget spent, 4 refused |
| done_bytes | output | clog2(MAX_LEN+1) | Bytes completed |
| rd_data | output | 8*MAX_LEN | Read result, byte j at bits [8j+7:8j] |
| xcv_start | output | 1 | Starts one transceiver attempt |
| xcv_cmd | output | 4 | Command for the attempt |
| xcv_addr | output | ADDR_W | Address for the attempt |
| xcv_len_m1 | output | 4 | Chunk byte count minus 1 |
| xcv_wdata | output | 128 | Chunk write bytes |
| xcv_done | input | 1 | Attempt finished |
| xcv_stat | input | 11 | [3:0] error flags, [5:4] reply type, [10:6] reply byte count |
| xcv_rdata | input | 128 | Chunk read bytes |
| xcv_stat_clr | output | 1 | Clears the transceiver status flags |

## Verification
Results fall due at fixed offsets from each stimulus:

- The first `xcv_start` falls in the cycle after the accepting edge.
- A follow-on chunk starts one cycle after the ACK's `xcv_done`.
- A retry starts `SETTLE_CYC`+1 cycles after the failing `xcv_done`, or after the last timeout cycle, `TMO_CYC` cycles past its start.
- `done_valid` rises one cycle after the deciding reply, or in the cycle right after acceptance for a rejected request.

The transceiver model in the bench stamps every start with a cycle number. The bench compares the gaps between starts against these offsets, so a late or early attempt shows up as a wrong gap. Sweeps cover:

- every length for both directions;
- every command code for both directions;
- every error and defer count up to and past its budget.

All ports are sampled on the falling clock edge.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  localparam int CHUNK_BYTES = 16;
  localparam int CHUNK_W     = CHUNK_BYTES * 8;
  localparam int STAT_W      = 11;

  // command codes
  localparam logic [3:0] CMD_I2C_WR   = 4'h0;
  localparam logic [3:0] CMD_I2C_RD   = 4'h1;
  localparam logic [3:0] CMD_I2C_STAT = 4'h2;
  localparam logic [3:0] CMD_MOT_WR   = 4'h4;
  localparam logic [3:0] CMD_MOT_RD   = 4'h5;
  localparam logic [3:0] CMD_NAT_WR   = 4'h8;
  localparam logic [3:0] CMD_NAT_RD   = 4'h9;

  // reply types in status bits [5:4]
  localparam logic [1:0] RPL_ACK = 2'd0;

  typedef enum logic [2:0] {
    SQ_OK      = 3'd0,
    SQ_BAD_CMD = 3'd1,
    SQ_ERR_EXH = 3'd2,
    SQ_DEF_EXH = 3'd3,
    SQ_NACK    = 3'd4
  } seq_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_SETTLE, S_FIN
  } seq_state_e;
endpackage

// File: rtl/aux_cmd_check.sv
module aux_cmd_check import aux_seq_pkg::*; #(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7
) (
  input  logic             is_write,
  input  logic [3:0]       cmd,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  logic dir_ok;
  always_comb begin
    if (is_write) dir_ok = (cmd == CMD_I2C_WR) || (cmd == CMD_MOT_WR) || (cmd == CMD_NAT_WR);
    else          dir_ok = (cmd == CMD_I2C_RD) || (cmd == CMD_I2C_STAT) ||
                           (cmd == CMD_MOT_RD) || (cmd == CMD_NAT_RD);
    ok = dir_ok && (len != '0) && (int'(len) <= MAX_LEN);
  end
endmodule

// File: rtl/aux_cycle_timer.sv
module aux_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/aux_retry_budget.sv
module aux_retry_budget #(
  parameter int TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic use_one,
  output logic last
);
  localparam int CW = $clog2(TRIES + 1);
  logic [CW-1:0] used_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       used_q <= '0;
    else if (clr)     used_q <= '0;
    else if (use_one) used_q <= used_q + 1'b1;
  end
  assign last = (int'(used_q) >= TRIES - 1);
endmodule

// File: rtl/aux_retry_seq.sv
module aux_retry_seq import aux_seq_pkg::*; #(
  parameter int ADDR_W    = 20,
  parameter int MAX_LEN   = 64,
  parameter int CLK_HZ    = 100_000_000,
  parameter int TMO_US    = 40_000,
  parameter int SETTLE_US = 1,
  parameter int ERR_TRIES = 3,
  parameter int DEF_TRIES = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [3:0]                     req_cmd,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [$clog2(MAX_LEN+1)-1:0]   req_len,
  input  logic [MAX_LEN*8-1:0]           req_wdata,
  output logic                           done_valid,
  output logic [2:0]                     done_status,
  output logic [$clog2(MAX_LEN+1)-1:0]   done_bytes,
  output logic [MAX_LEN*8-1:0]           rd_data,
  output logic                           xcv_start,
  output logic [3:0]                     xcv_cmd,
  output logic [ADDR_W-1:0]              xcv_addr,
  output logic [3:0]                     xcv_len_m1,
  output logic [127:0]                   xcv_wdata,
  input  logic                           xcv_done,
  input  logic [10:0]                    xcv_stat,
  input  logic [127:0]                   xcv_rdata,
  output logic                           xcv_stat_clr
);
  localparam int     LEN_W      = $clog2(MAX_LEN + 1);
  localparam longint TMO_RAW    = (longint'(CLK_HZ) * longint'(TMO_US)) / longint'(1000000);
  localparam longint SET_RAW    = (longint'(CLK_HZ) * longint'(SETTLE_US)) / longint'(1000000);
  localparam int     TMO_CYC    = (TMO_RAW < 1) ? 1 : int'(TMO_RAW);
  localparam int     SETTLE_CYC = (SET_RAW < 1) ? 1 : int'(SET_RAW);
  localparam int     TMR_MAX    = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
  localparam int     TMR_W      = $clog2(TMR_MAX + 1);

  seq_state_e               state_q;
  seq_status_e              status_q;
  logic [3:0]               cmd_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [LEN_W-1:0]         len_q, off_q;
  logic [MAX_LEN*8-1:0]     wbuf_q, rbuf_q;
  logic                     clr_q;

  logic                     accept, cmd_ok;
  logic [LEN_W-1:0]         rem, off_nx;
  logic [4:0]               clen, clen_m1, rcnt, acc;
  logic                     fire, err_hit, dfr_hit, ack_hit, go_settle, budget_clr;
  logic                     err_last, def_last, tmr_expired, tmr_load;
  logic [TMR_W-1:0]         tmr_val;

  assign accept = req_valid && req_ready;

  aux_cmd_check #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cmd_check (
    .is_write(req_write), .cmd(req_cmd), .len(req_len), .ok(cmd_ok)
  );

  always_comb begin
    rem     = len_q - off_q;
    clen    = (rem > LEN_W'(CHUNK_BYTES)) ? 5'd16 : rem[4:0];
    clen_m1 = clen - 5'd1;
    rcnt    = xcv_stat[10:6];
    acc     = (rcnt > clen) ? clen : rcnt;
    off_nx  = off_q + LEN_W'(acc);
    fire    = (state_q == S_WAIT) && (xcv_done || tmr_expired);
    err_hit = fire && (!xcv_done || (|xcv_stat[3:0]));
    dfr_hit = fire && !err_hit && xcv_stat[5];
    ack_hit = fire && !err_hit && (xcv_stat[5:4] == RPL_ACK) && (acc != 5'd0);
    go_settle  = (err_hit && !err_last) || (dfr_hit && !def_last);
    budget_clr = accept || ack_hit;
    tmr_load   = (state_q == S_ISSUE) || go_settle;
    tmr_val    = (state_q == S_ISSUE) ? TMR_W'(TMO_CYC - 1) : TMR_W'(SETTLE_CYC - 1);
  end

  aux_cycle_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  aux_retry_budget #(.TRIES(ERR_TRIES)) u_err_budget (
    .clk(clk), .rst_n(rst_n), .clr(budget_clr), .use_one(err_hit), .last(err_last)
  );

  aux_retry_budget #(.TRIES(DEF_TRIES)) u_def_budget (
    .clk(clk), .rst_n(rst_n), .clr(budget_clr), .use_one(dfr_hit), .last(def_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= SQ_OK;
      cmd_q    <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      off_q    <= '0;
      wbuf_q   <= '0;
      clr_q    <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          cmd_q  <= req_cmd;
          addr_q <= req_addr;
          len_q  <= req_len;
          off_q  <= '0;
          wbuf_q <= req_wdata;
          if (cmd_ok) state_q <= S_ISSUE;
          else begin
            status_q <= SQ_BAD_CMD;
            state_q  <= S_FIN;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (fire) begin
          if (err_hit) begin
            clr_q <= 1'b1;
            if (err_last) begin status_q <= SQ_ERR_EXH; state_q <= S_FIN; end
            else state_q <= S_SETTLE;
          end else if (dfr_hit) begin
            clr_q <= 1'b1;
            if (def_last) begin status_q <= SQ_DEF_EXH; state_q <= S_FIN; end
            else state_q <= S_SETTLE;
          end else if (ack_hit) begin
            off_q  <= off_nx;
            addr_q <= addr_q + ADDR_W'(acc);
            if (off_nx >= len_q) begin status_q <= SQ_OK; state_q <= S_FIN; end
            else state_q <= S_ISSUE;
          end else begin
            status_q <= SQ_NACK;
            state_q  <= S_FIN;
          end
        end
        S_SETTLE: if (tmr_expired) state_q <= S_ISSUE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbuf_q <= '0;
    else if (ack_hit) begin
      for (int i = 0; i < CHUNK_BYTES; i++) begin
        if ((i < int'(acc)) && (int'(off_q) + i < MAX_LEN))
          rbuf_q[(int'(off_q) + i)*8 +: 8] <= xcv_rdata[i*8 +: 8];
      end
    end
  end

  for (genvar g = 0; g < CHUNK_BYTES; g++) begin : g_wslice
    assign xcv_wdata[g*8 +: 8] = (int'(off_q) + g < MAX_LEN) ?
                                 wbuf_q[(int'(off_q) + g)*8 +: 8] : 8'h00;
  end

  assign req_ready    = (state_q == S_IDLE);
  assign done_valid   = (state_q == S_FIN);
  assign done_status  = status_q;
  assign done_bytes   = off_q;
  assign rd_data      = rbuf_q;
  assign xcv_start    = (state_q == S_ISSUE);
  assign xcv_cmd      = cmd_q;
  assign xcv_addr     = addr_q;
  assign xcv_len_m1   = clen_m1[3:0];
  assign xcv_stat_clr = clr_q;
endmodule

// File: rtl/aux_seq_checker.sv
module aux_seq_checker #(
  parameter int MAX_LEN = 64
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [$clog2(MAX_LEN+1)-1:0] req_len,
  input logic                         done_valid,
  input logic [2:0]                   done_status,
  input logic [$clog2(MAX_LEN+1)-1:0] done_bytes,
  input logic                         xcv_start
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  logic [LEN_W-1:0] len_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_seen <= '0;
    else if (req_valid && req_ready) len_seen <= req_len;
  end

  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start |-> !req_ready);
  // R1
  done_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));
  // R2
  bad_cmd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_status == 3'd1) |-> (done_bytes == '0));
  // R10
  ok_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_status == 3'd0) |-> (done_bytes == len_seen));
  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xcv_start |=> !xcv_start);
  // R7
  partial_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_bytes <= len_seen));
endmodule

bind aux_retry_seq aux_seq_checker #(.MAX_LEN(MAX_LEN)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .done_valid(done_valid), .done_status(done_status),
  .done_bytes(done_bytes), .xcv_start(xcv_start)
);

// File: tb/test_aux_retry_seq.sv
module test_aux_retry_seq;
  localparam int AW = 20, ML = 64, LW = 7;
  localparam int LAT = 2, ETR = 3, DTR = 7, SETC = 4, TMOC = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic [3:0]    req_cmd = 0;
  logic [AW-1:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [ML*8-1:0] req_wdata = 0;
  logic          req_ready, done_valid, xcv_start, xcv_stat_clr;
  logic [2:0]    done_status;
  logic [LW-1:0] done_bytes;
  logic [ML*8-1:0] rd_data;
  logic [3:0]    xcv_cmd, xcv_len_m1;
  logic [AW-1:0] xcv_addr;
  logic [127:0]  xcv_wdata;
  logic          xcv_done = 0;
  logic [10:0]   xcv_stat = 0;
  logic [127:0]  xcv_rdata = 0;

  aux_retry_seq #(.ADDR_W(AW), .MAX_LEN(ML), .CLK_HZ(100_000), .TMO_US(40_000),
                  .SETTLE_US(40), .ERR_TRIES(ETR), .DEF_TRIES(DTR)) i_aux_retry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .done_valid(done_valid), .done_status(done_status),
    .done_bytes(done_bytes), .rd_data(rd_data), .xcv_start(xcv_start), .xcv_cmd(xcv_cmd),
    .xcv_addr(xcv_addr), .xcv_len_m1(xcv_len_m1), .xcv_wdata(xcv_wdata),
    .xcv_done(xcv_done), .xcv_stat(xcv_stat), .xcv_rdata(xcv_rdata), .xcv_stat_clr(xcv_stat_clr)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  // reply script per attempt of the current request
  int sc_err[32], sc_rt[32], sc_cnt[32];
  bit sc_sil[32];
  int n_start, n_clr, wd_bad, cur_base;
  bit cur_wr;
  int rec_addr[64], rec_lm1[64], rec_cyc[64];
  bit pend = 0;
  int due, pend_idx, pend_addr, pend_lm1;

  function automatic int rpat(int a); return (a * 7 + 3) & 255; endfunction
  function automatic int wpat(int j); return (j * 13 + 5) & 255; endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic script_clear();
    for (int i = 0; i < 32; i++) begin
      sc_err[i] = 0; sc_rt[i] = 0; sc_cnt[i] = -1; sc_sil[i] = 0;
    end
  endtask

  // transceiver model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      xcv_done = 1'b0;
      if (xcv_stat_clr) n_clr++;
      if (pend && cyc == due) begin
        int c;
        c = (sc_cnt[pend_idx] < 0) ? pend_lm1 + 1 : sc_cnt[pend_idx];
        xcv_stat  = {5'(c), 2'(sc_rt[pend_idx]), 4'(sc_err[pend_idx])};
        for (int i = 0; i < 16; i++) xcv_rdata[i*8 +: 8] = 8'(rpat(pend_addr + i));
        xcv_done = 1'b1;
        pend = 0;
      end
      if (xcv_start) begin
        int k;
        k = (n_start < 31) ? n_start : 31;
        if (n_start < 64) begin
          rec_addr[n_start] = int'(xcv_addr);
          rec_lm1[n_start]  = int'(xcv_len_m1);
          rec_cyc[n_start]  = cyc;
        end
        if (cur_wr)
          for (int i = 0; i <= int'(xcv_len_m1); i++)
            if (int'(xcv_wdata[i*8 +: 8]) != wpat(int'(xcv_addr) - cur_base + i)) wd_bad++;
        if (!sc_sil[k]) begin
          pend = 1; due = cyc + LAT; pend_idx = k;
          pend_addr = int'(xcv_addr); pend_lm1 = int'(xcv_len_m1);
        end
        n_start++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  int st, nb, first_start;
  task automatic do_req(bit wr, int cmd, int base, int len);
    n_start = 0; n_clr = 0; wd_bad = 0; cur_base = base; cur_wr = wr;
    @(negedge clk);
    for (int j = 0; j < ML; j++) req_wdata[j*8 +: 8] = 8'(wpat(j));
    req_valid = 1; req_write = wr; req_cmd = 4'(cmd); req_addr = AW'(base); req_len = LW'(len);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    first_start = int'(xcv_start);
    while (!done_valid) @(negedge clk);
    st = int'(done_status); nb = int'(done_bytes);
  endtask

  task automatic check_read_data(string tag, int base, int len);
    int bad;
    bad = 0;
    for (int j = 0; j < len; j++) if (int'(rd_data[j*8 +: 8]) != rpat(base + j)) bad++;
    chk(tag, bad, 0);
  endtask

  initial begin
    script_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 no done after reset", int'(done_valid), 0);
    chk("R1 no start after reset", int'(xcv_start), 0);
    rst_n = 1;

    // R3 R10 R8 read sweep over every length
    for (int len = 1; len <= ML; len++) begin
      int nc, badA, badG;
      do_req(0, 9, 100 * len, len);
      nc = (len + 15) / 16;
      chk("R10 read status", st, 0);
      chk("R10 read bytes", nb, len);
      chk("R3 read chunk count", n_start, nc);
      chk("R8 first attempt no delay", first_start, 1);
      badA = 0; badG = 0;
      for (int k = 0; k < nc; k++) begin
        int cl;
        cl = (len - 16 * k > 16) ? 16 : len - 16 * k;
        if (rec_addr[k] != 100 * len + 16 * k || rec_lm1[k] != cl - 1) badA++;
        if (k > 0 && rec_cyc[k] - rec_cyc[k-1] != LAT + 1) badG++;
      end
      chk("R3 chunk addr/len", badA, 0);
      chk("R8 chunk gap", badG, 0);
      check_read_data("R6 read data", 100 * len, len);
    end

    // R3 write sweep
    for (int len = 1; len <= ML; len++) begin
      do_req(1, 8, 7 * len, len);
      chk("R10 write status", st, 0);
      chk("R10 write bytes", nb, len);
      chk("R3 write chunk count", n_start, (len + 15) / 16);
      chk("R3 write data slices", wd_bad, 0);
    end

    // R2 command sweep for both directions
    for (int wr = 0; wr < 2; wr++)
      for (int c = 0; c < 16; c++) begin
        bit ok;
        ok = wr ? (c == 0 || c == 4 || c == 8) : (c == 1 || c == 2 || c == 5 || c == 9);
        do_req(bit'(wr), c, 40, 4);
        chk("R2 cmd status", st, ok ? 0 : 1);
        chk("R2 cmd attempts", n_start, ok ? 1 : 0);
        chk("R2 cmd bytes", nb, ok ? 4 : 0);
      end
    // R2 lengths out of range
    do_req(0, 9, 0, 0);
    chk("R2 len zero", st, 1);
    chk("R2 len zero no start", n_start, 0);
    do_req(0, 9, 0, 65);
    chk("R2 len too big", st, 1);

    // R4 error sweep
    for (int k = 0; k <= ETR; k++) begin
      script_clear();
      for (int i = 0; i < k; i++) sc_err[i] = 1 << (i % 4);
      do_req(0, 1, 300, 8);
      chk("R4 err status", st, (k < ETR) ? 0 : 2);
      chk("R4 err attempts", n_start, (k < ETR) ? k + 1 : ETR);
      chk("R4 clear pulses", n_clr, (k < ETR) ? k : ETR);
      chk("R4 err bytes", nb, (k < ETR) ? 8 : 0);
      if (k >= 1) chk("R8 retry gap", rec_cyc[1] - rec_cyc[0], LAT + 1 + SETC);
    end

    // R5 defer sweep
    for (int k = 0; k <= DTR; k++) begin
      script_clear();
      for (int i = 0; i < k; i++) sc_rt[i] = 2 + (i % 2);
      do_req(0, 5, 900, 12);
      chk("R5 defer status", st, (k < DTR) ? 0 : 3);
      chk("R5 defer attempts", n_start, (k < DTR) ? k + 1 : DTR);
      chk("R5 defer clears", n_clr, (k < DTR) ? k : DTR);
      if (k < DTR) check_read_data("R5 data after defers", 900, 12);
    end

    // R4 R5 separate budgets in one chunk
    script_clear();
    sc_err[0] = 2; sc_rt[1] = 2; sc_err[2] = 4; for (int i = 3; i < 8; i++) sc_rt[i] = 3;
    do_req(1, 4, 50, 10);
    chk("R5 mixed budgets status", st, 0);
    chk("R5 mixed budgets attempts", n_start, 9);

    // R11 budgets restart per chunk
    script_clear();
    sc_err[0] = 1; sc_err[1] = 8; sc_err[3] = 1; sc_err[4] = 2;
    do_req(0, 9, 2000, 32);
    chk("R11 per-chunk status", st, 0);
    chk("R11 per-chunk attempts", n_start, 6);
    chk("R11 second chunk addr", rec_addr[3], 2016);

    // R6 short ACK advances by acknowledged count
    script_clear();
    sc_cnt[0] = 5;
    do_req(0, 9, 500, 20);
    chk("R6 short ack status", st, 0);
    chk("R6 second addr", rec_addr[1], 505);
    chk("R6 second len_m1", rec_lm1[1], 14);
    check_read_data("R6 short ack data", 500, 20);
    // R6 oversized count is clamped
    script_clear();
    sc_cnt[0] = 16;
    do_req(0, 9, 700, 4);
    chk("R6 clamp bytes", nb, 4);
    chk("R6 clamp status", st, 0);

    // R7 refusal on second chunk
    script_clear();
    sc_rt[1] = 1;
    do_req(0, 9, 1200, 40);
    chk("R7 nack status", st, 4);
    chk("R7 nack bytes", nb, 16);
    chk("R7 nack attempts", n_start, 2);
    // R7 zero-count ACK
    script_clear();
    sc_cnt[0] = 0;
    do_req(1, 0, 60, 6);
    chk("R7 zero ack status", st, 4);
    chk("R7 zero ack bytes", nb, 0);

    // R9 missing done is a timeout error
    script_clear();
    sc_sil[0] = 1;
    do_req(0, 9, 3000, 3);
    chk("R9 timeout status", st, 0);
    chk("R9 timeout attempts", n_start, 2);
    chk("R9 timeout retry gap", rec_cyc[1] - rec_cyc[0], TMOC + 1 + SETC);
    chk("R9 timeout clears", n_clr, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule